// File: doc/BRIEF.md
# Modulo Timer PWM Channel

This block is a single timer channel that produces a pulse-width-modulated waveform. A free-running up-counter, advanced by a selectable prescaler, runs from zero to a programmable modulo value and then returns to zero. That return is the overflow event, and the time between two overflows is the PWM period. One output-compare channel ends the pulse when the counter reaches the compare value. A polarity bit selects whether the pin is driven high or low during the pulse.

Software programs the channel through a small write port. The port holds the modulo value, the compare value, a control word with the prescaler select and polarity, and a write-one-to-clear flag register. The compare register is not buffered, so a write takes effect on the very next counter step. A write that moves the compare value behind the counter therefore loses the compare for the rest of that period. Two sticky flags record overflow and compare events.

Top module: `modtimer_pwm`

## Requirements
- R1: While reset is asserted, and right after it is released, `pwm_out`, `ovf_flag` and `cmp_flag` are 0. Reset also clears the counter and the prescaler, sets the modulo register to 16'hFFFF, and clears the compare register and the control word.
- R2: Writes go to the register selected by `wr_addr`: 0 is modulo and 1 is compare. On each counter step the counter goes up by one. When the counter is at or above the modulo value, the next step returns it to 0 and is the overflow event. With divide-by-1, a modulo value M gives a period of M+1 clocks (255 gives 256).
- R3: With polarity 0 the pin goes high at overflow and low when the counter steps onto the compare value. With modulo 255, a compare value of 128 gives 128 high clocks out of every 256.
- R4: Control word (address 2): bit 3 is polarity. With polarity 1 the pin goes low at overflow and high at compare. With modulo 255 and compare 64, the pin is high for 192 of every 256 clocks.
- R5: Control bits [2:0] select the prescaler. A value s from 0 to 6 makes the counter step once every 2^s clocks. The value 7 steps it every clock. The pin changes only on a counter step.
- R6: Compare writes are unbuffered. Suppose the compare value is lowered below the current count while the counter has not yet reached the old compare value. Then no compare happens in that period: the pin keeps its overflow level until the next overflow and `cmp_flag` stays 0. From the next period on, the new value applies.
- R7: A compare value greater than the modulo value never matches. The pin stays at its overflow level, high for polarity 0.
- R8: A compare value of 0 matches on the overflow step and takes priority over the overflow action. With polarity 0 the pin stays low.
- R9: `ovf_flag` (bit 0) and `cmp_flag` (bit 1) set on their events and stay set. Writing 1 to a bit at address 3 clears only that flag. A clear in the same cycle as a new event leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 modulo, 1 compare, 2 control, 3 flag clear |
| wr_data | input | 16 | Write data |
| pwm_out | output | 1 | PWM pin |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky compare flag |

## Verification
The hardest case is the late compare write. The bench locks onto an overflow, waits until the count has passed the new value, and then lowers the compare value. A design that buffered the write, or that matched with a "greater or equal" test, would end the pulse early and set the compare flag. The bench also covers compare 0 and compare above modulo, where a wrong priority between overflow and compare shows up as a full or empty pulse in the wrong place. The reserved prescaler code is tested too, because a design that decoded it as a deeper divide would stretch the period. The flag tests clear one flag and check that the other is unchanged, which catches clears that hit the wrong bit or both bits.

// File: rtl/modtimer_pwm.sv
module modtimer_pwm #(
  parameter int CNT_W = 16,
  parameter int PS_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             pwm_out,
  output logic             ovf_flag,
  output logic             cmp_flag
);
  localparam int PRE_W = (1 << PS_W) - 2;
  localparam logic [PS_W-1:0] SEL_RSVD = '1;

  logic [PRE_W-1:0] pre_q, pre_mask;
  logic [CNT_W-1:0] cnt_q, mod_q, cmp_q, cnt_nxt;
  logic [PS_W-1:0]  sel_q;
  logic             pol_q, tick, wrap, hit;
  logic             wr_mod, wr_cmp, wr_ctl, clr_ovf, clr_cmp;

  assign wr_mod  = wr_en && wr_addr == 2'd0;
  assign wr_cmp  = wr_en && wr_addr == 2'd1;
  assign wr_ctl  = wr_en && wr_addr == 2'd2;
  assign clr_ovf = wr_en && wr_addr == 2'd3 && wr_data[0];
  assign clr_cmp = wr_en && wr_addr == 2'd3 && wr_data[1];

  assign pre_mask = (sel_q == SEL_RSVD) ? '0 : ~({PRE_W{1'b1}} << sel_q);
  assign tick     = (pre_q & pre_mask) == pre_mask;
  assign wrap     = tick && (cnt_q >= mod_q);
  assign cnt_nxt  = wrap ? '0 : cnt_q + 1'b1;
  assign hit      = tick && (cnt_nxt == cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
      if (tick) cnt_q <= cnt_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_q <= '1;
      cmp_q <= '0;
      sel_q <= '0;
      pol_q <= 1'b0;
    end else begin
      if (wr_mod) mod_q <= wr_data;
      if (wr_cmp) cmp_q <= wr_data;
      if (wr_ctl) begin
        sel_q <= wr_data[PS_W-1:0];
        pol_q <= wr_data[PS_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_out  <= 1'b0;
      ovf_flag <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      if (hit)       pwm_out <= pol_q;
      else if (wrap) pwm_out <= ~pol_q;
      ovf_flag <= wrap | (ovf_flag & ~clr_ovf);
      cmp_flag <= hit  | (cmp_flag & ~clr_cmp);
    end
  end
endmodule

module modtimer_pwm_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [CNT_W-1:0] wr_data,
  input logic             pwm_out,
  input logic             ovf_flag,
  input logic             cmp_flag,
  input logic             tick,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] mod_q,
  input logic [CNT_W-1:0] cmp_q,
  input logic             pol_q
);
  // R9
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !(wr_en && wr_addr == 2'd3 && wr_data[0])) |=> ovf_flag);
  // R9
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_flag && !(wr_en && wr_addr == 2'd3 && wr_data[1])) |=> cmp_flag);
  // R5
  pin_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pwm_out));
  // R5
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q < mod_q) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  // R4
  ovf_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q >= mod_q && cmp_q != '0) |=> (pwm_out == !$past(pol_q)));
endmodule

bind modtimer_pwm modtimer_pwm_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .pwm_out(pwm_out), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag), .tick(tick),
  .cnt_q(cnt_q), .mod_q(mod_q), .cmp_q(cmp_q), .pol_q(pol_q)
);

// File: tb/modtimer_pwm_tb.sv
module modtimer_pwm_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm_out, ovf_flag, cmp_flag;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  logic [2:0] exp_q[$];

  modtimer_pwm dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_out(pwm_out), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
  );

  always #(CLK_P/2) clk = ~clk;

  // reference model from the requirements
  int m_pre, m_cnt, m_mod, m_cmp, m_sel;
  bit m_pol, m_pin, m_ovf, m_cf;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_mod = 16'hFFFF; m_cmp = 0; m_sel = 0;
      m_pol = 0; m_pin = 0; m_ovf = 0; m_cf = 0;
    end else begin
      int div, nxt;
      bit step, ov, cm;
      div  = (m_sel == 7) ? 1 : (1 << m_sel);
      step = (m_pre % div) == div - 1;
      ov   = step && (m_cnt >= m_mod);
      nxt  = ov ? 0 : m_cnt + 1;
      cm   = step && (nxt == m_cmp);
      if (step) m_cnt = nxt;
      if (cm) m_pin = m_pol;
      else if (ov) m_pin = !m_pol;
      if (ov) m_ovf = 1;
      else if (wr_en && wr_addr == 3 && wr_data[0]) m_ovf = 0;
      if (cm) m_cf = 1;
      else if (wr_en && wr_addr == 3 && wr_data[1]) m_cf = 0;
      if (wr_en && wr_addr == 0) m_mod = wr_data;
      if (wr_en && wr_addr == 1) m_cmp = wr_data;
      if (wr_en && wr_addr == 2) begin m_sel = wr_data[2:0]; m_pol = wr_data[3]; end
      m_pre = (m_pre + 1) % 64;
    end
    exp_q.push_back({m_pin, m_ovf, m_cf});
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [2:0] e;
      e = exp_q.pop_front();
      checks++;
      if ({pwm_out, ovf_flag, cmp_flag} !== e) begin
        errors++;
        $display("FAIL %s scoreboard pwm/ovf/cmp actual %b expected %b",
                 cur_req, {pwm_out, ovf_flag, cmp_flag}, e);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = a[1:0]; wr_data = d[15:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic setup(input int md, input int cp, input int ctl);
    do_reset();
    wr(0, md); wr(1, cp); wr(2, ctl);
  endtask

  task automatic measure(input int n, output int hi, output int rises);
    bit prev;
    hi = 0; rises = 0; prev = pwm_out;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) hi++;
      if (pwm_out && !prev) rises++;
      prev = pwm_out;
    end
  endtask

  task automatic wait_ovf();
    wr(3, 1);
    for (int i = 0; i < 2000 && !ovf_flag; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hi, rs;
    @(negedge clk);
    cur_req = "R1";
    do_reset();
    check(pwm_out == 0 && ovf_flag == 0 && cmp_flag == 0, "R1 reset outputs",
          {pwm_out, ovf_flag, cmp_flag}, 0);

    cur_req = "R3";
    setup(255, 128, 0);
    repeat (300) @(negedge clk);
    measure(512, hi, rs);
    check(hi == 256, "R3 high clocks at 50%", hi, 256);
    check(rs == 2, "R2 period 256 rising edges", rs, 2);

    cur_req = "R4";
    setup(255, 64, 8);
    repeat (300) @(negedge clk);
    measure(256, hi, rs);
    check(hi == 192, "R4 polarity 1 high clocks", hi, 192);

    cur_req = "R5";
    setup(15, 8, 2);
    repeat (200) @(negedge clk);
    measure(256, hi, rs);
    check(rs == 4, "R5 divide-by-4 period", rs, 4);
    check(hi == 128, "R5 divide-by-4 high clocks", hi, 128);
    setup(15, 4, 7);
    repeat (100) @(negedge clk);
    measure(64, hi, rs);
    check(rs == 4, "R5 reserved select acts as divide-by-1", rs, 4);
    check(hi == 16, "R5 reserved select high clocks", hi, 16);

    cur_req = "R7";
    setup(255, 300, 0);
    repeat (300) @(negedge clk);
    wr(3, 2);
    measure(256, hi, rs);
    check(hi == 256, "R7 compare above modulo never clears", hi, 256);
    check(cmp_flag == 0, "R7 no compare flag", cmp_flag, 0);

    cur_req = "R8";
    setup(255, 0, 0);
    repeat (300) @(negedge clk);
    measure(256, hi, rs);
    check(hi == 0, "R8 compare 0 wins at overflow", hi, 0);
    check(cmp_flag == 1, "R8 compare flag set at 0", cmp_flag, 1);

    cur_req = "R6";
    setup(255, 200, 0);
    repeat (300) @(negedge clk);
    wait_ovf();
    check(ovf_flag == 1, "R6 overflow located", ovf_flag, 1);
    wr(3, 2);
    repeat (148) @(negedge clk);
    wr(1, 100);
    measure(90, hi, rs);
    check(hi == 90, "R6 missed compare keeps pin high", hi, 90);
    check(cmp_flag == 0, "R6 missed compare raises no flag", cmp_flag, 0);
    wait_ovf();
    measure(256, hi, rs);
    check(hi == 100, "R6 new compare applies next period", hi, 100);

    cur_req = "R9";
    setup(255, 128, 0);
    repeat (300) @(negedge clk);
    check(ovf_flag == 1 && cmp_flag == 1, "R9 both flags set", {ovf_flag, cmp_flag}, 3);
    wait_ovf();
    wr(3, 1);
    check(ovf_flag == 0, "R9 overflow flag cleared", ovf_flag, 0);
    check(cmp_flag == 1, "R9 compare flag untouched", cmp_flag, 1);
    repeat (260) @(negedge clk);
    check(ovf_flag == 1, "R9 overflow flag set again and held", ovf_flag, 1);

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule